// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

This block is a synthesizable model of a 2 KB byte-wide non-volatile memory reached over a four-wire serial link in clock mode 0. A host drives chip select low, shifts in an 8-bit command, and for array access a 16-bit address, most significant bit first. Reads then stream bytes out from consecutive addresses. Writes stream bytes in to consecutive addresses. Both kinds of access wrap from the top of the array back to address zero.

A status byte holds the busy flag, a write-enable latch, two block-protect bits, two stored watchdog bits and a protect-enable bit. The protect-enable bit works together with an active-low write-protect pin to guard the status byte. Written bytes collect in a small buffer. They are committed only when chip select rises after a whole number of bytes. The commit then holds the busy flag for a fixed number of system clock cycles, and during that time the block answers only status reads.

The serial inputs are sampled by a free-running system clock that runs much faster than the serial clock. Serial clock edges are found by comparing each sample with the one before it.

Top module: `spi_eeprom`

## Requirements
- R1: Serial input is sampled on the rising serial clock edge, most significant bit first. `so` changes only after a falling serial clock edge while selected, and reads 0 while `cs_n` is high.
- R2: Command codes are 0x06 set-latch, 0x04 clear-latch, 0x05 status read, 0x01 status write, 0x03 array read and 0x02 array write. Any other code is ignored until the next deselect.
- R3: Command 0x06 sets the write-enable latch and command 0x04 clears it.
- R4: Status byte layout is bit7 protect-enable, bit6 zero, bits5:4 watchdog, bits3:2 block protect, bit1 write-enable latch, bit0 busy. A status read returns this byte again for every further byte clocked.
- R5: An array read takes a 16-bit address and keeps only the low 11 bits. It returns consecutive bytes, and after 0x7FF the next address is 0x000.
- R6: An array write is ignored when the latch is clear. A write whose final byte is incomplete at deselect is dropped entirely: the busy flag is not set and the latch stays set.
- R7: Write bytes land at consecutive addresses that wrap from 0x7FF to 0x000. Only the first BUF_BYTES bytes of one write are kept.
- R8: After a commit the busy flag reads 1 for exactly BUSY_CYCLES clock cycles. During that time every command except the status read is ignored.
- R9: The write-enable latch clears when the busy period ends, and a commit can start only when the latch is set.
- R10: Block protect value 00 protects nothing, 01 protects the upper quarter (0x600-0x7FF), 10 the upper half (0x400-0x7FF) and 11 all addresses. Protected bytes keep their value, while the unprotected bytes of the same write are stored.
- R11: A status write needs the latch. It updates bits 7, 5, 4, 3 and 2 from the data byte. It does not touch the busy and latch bits, and bit 6 stays 0.
- R12: A status write is dropped when protect-enable is 1 and `wp_n` is low. Array writes outside the protected blocks are not affected by the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low write-protect pin |
| so | output | 1 | Serial data to the host |

## Verification
The bench builds the block with BUF_BYTES = 8 and BUSY_CYCLES = 500, and keeps the default 11-bit address. The small buffer makes buffer overflow reachable with a ten-byte write. The long busy period leaves room for several whole transactions to be sent while the busy flag is set, so the rule that commands are ignored during busy can be observed at the ports. The default address width places the wrap point and every block-protect boundary where the requirements name them.

// File: rtl/spi_eeprom.sv
module spi_eeprom #(
  parameter int ADDR_BITS   = 11,
  parameter int BUF_BYTES   = 16,
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic so
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int AH_W  = ADDR_BITS - 8;
  localparam int BW    = $clog2(BUF_BYTES + 1);
  localparam int IW    = $clog2(BUF_BYTES);
  localparam int CW    = $clog2(BUSY_CYCLES + 1);

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {S_OPC, S_AH, S_AL, S_RD, S_WR, S_SR, S_WS, S_IGN} st_t;

  logic [7:0] mem  [DEPTH];
  logic [7:0] wbuf [BUF_BYTES];

  st_t                  st;
  logic                 sck_d, cs_d;
  logic [6:0]           rx;
  logic [2:0]           bcnt;
  logic [7:0]           tx;
  logic                 rd_op;
  logic [AH_W-1:0]      ah;
  logic [ADDR_BITS-1:0] addr, wstart;
  logic [BW-1:0]        wcnt, ci;
  logic                 arr_go;
  logic [CW-1:0]        bcyc;
  logic [4:0]           ws_v;
  logic                 ws_got;
  logic                 wpen, wel;
  logic [1:0]           wd, bl;

  logic                 rise, fall, byte_done, wip, wp_lock, wen;
  logic [7:0]           byte_in, status;
  logic [ADDR_BITS-1:0] a_in, waddr;

  function automatic logic prot(input logic [1:0] b, input logic [ADDR_BITS-1:0] a);
    case (b)
      2'd0:    prot = 1'b0;
      2'd1:    prot = &a[ADDR_BITS-1 -: 2];
      2'd2:    prot = a[ADDR_BITS-1];
      default: prot = 1'b1;
    endcase
  endfunction

  assign rise      = !cs_n && sck && !sck_d;
  assign fall      = !cs_n && !sck && sck_d;
  assign byte_in   = {rx, si};
  assign byte_done = rise && (bcnt == 3'd7);
  assign a_in      = {ah, byte_in};
  assign wip       = (bcyc != '0);
  assign status    = {wpen, 1'b0, wd, bl, wel, wip};
  assign wp_lock   = wpen && !wp_n;
  assign waddr     = wstart + ADDR_BITS'(ci);
  assign wen       = arr_go && (ci < wcnt) && !prot(bl, waddr);

  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wbuf[ci[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!cs_n && byte_done && st == S_WR && wcnt < BW'(BUF_BYTES))
      wbuf[wcnt[IW-1:0]] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OPC; sck_d <= 1'b0; cs_d <= 1'b1;
      rx <= '0; bcnt <= '0; tx <= '0; so <= 1'b0;
      rd_op <= 1'b0; ah <= '0; addr <= '0; wstart <= '0;
      wcnt <= '0; ci <= '0; arr_go <= 1'b0; bcyc <= '0;
      ws_v <= '0; ws_got <= 1'b0;
      wpen <= 1'b0; wel <= 1'b0; wd <= '0; bl <= '0;
    end else begin
      sck_d <= sck;
      cs_d  <= cs_n;
      if (wip) begin
        bcyc <= bcyc - 1'b1;
        if (bcyc == CW'(1)) wel <= 1'b0;
      end
      if (arr_go) begin
        if (ci < wcnt) ci <= ci + 1'b1;
        else           arr_go <= 1'b0;
      end
      if (cs_n) begin
        st <= S_OPC; bcnt <= '0; tx <= '0; so <= 1'b0;
        if (!cs_d) begin
          if (st == S_WR && bcnt == 3'd0 && wcnt != '0) begin
            bcyc <= CW'(BUSY_CYCLES); ci <= '0; arr_go <= 1'b1;
          end else if (st == S_WS && bcnt == 3'd0 && ws_got && !wp_lock) begin
            wpen <= ws_v[4]; wd <= ws_v[3:2]; bl <= ws_v[1:0];
            bcyc <= CW'(BUSY_CYCLES);
          end
        end
      end else begin
        if (fall) begin
          so <= tx[7];
          tx <= {tx[6:0], 1'b0};
        end
        if (rise) begin
          rx   <= {rx[5:0], si};
          bcnt <= bcnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            S_OPC: begin
              if (wip) begin
                if (byte_in == OP_RDSR) begin tx <= status; st <= S_SR; end
                else st <= S_IGN;
              end else begin
                case (byte_in)
                  OP_WREN:  begin wel <= 1'b1; st <= S_IGN; end
                  OP_WRDI:  begin wel <= 1'b0; st <= S_IGN; end
                  OP_RDSR:  begin tx <= status; st <= S_SR; end
                  OP_WRSR:  begin ws_got <= 1'b0; st <= wel ? S_WS : S_IGN; end
                  OP_READ:  begin rd_op <= 1'b1; st <= S_AH; end
                  OP_WRITE: begin rd_op <= 1'b0; st <= wel ? S_AH : S_IGN; end
                  default:  st <= S_IGN;
                endcase
              end
            end
            S_AH: begin ah <= byte_in[AH_W-1:0]; st <= S_AL; end
            S_AL: begin
              if (rd_op) begin
                tx <= mem[a_in]; addr <= a_in + 1'b1; st <= S_RD;
              end else begin
                wstart <= a_in; wcnt <= '0; st <= S_WR;
              end
            end
            S_RD: begin tx <= mem[addr]; addr <= addr + 1'b1; end
            S_WR: if (wcnt < BW'(BUF_BYTES)) wcnt <= wcnt + 1'b1;
            S_SR: tx <= status;
            S_WS: if (!ws_got) begin
              ws_v <= {byte_in[7], byte_in[5:2]}; ws_got <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk #(
  parameter int BUSY_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic so,
  input logic wip,
  input logic wel
);
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run <= '0;
    else if (wip) run <= run + 32'd1;
    else          run <= '0;
  end

  AST_SO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (so == 1'b0)); // R1
  AST_SO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cs_n) && (so != $past(so))) |-> ($past(sck) == 1'b0 && $past(sck, 2) == 1'b1)); // R1
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (run == BUSY_CYCLES)); // R8
  AST_LATCH_CLEAR_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel); // R9
  AST_COMMIT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel)); // R9
endmodule

bind spi_eeprom spi_eeprom_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .so(so), .wip(wip), .wel(wel)
);

// File: tb/spi_eeprom_tb_top.sv
module spi_eeprom_tb_top;
  localparam int BUF  = 8;
  localparam int BUSY = 500;
  localparam int DEP  = 2048;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so;
  int   errors = 0, checks = 0;
  bit   done = 1'b0;
  logic [7:0] bmem [DEP];
  bit         known [DEP];
  logic [7:0] wb [16];
  logic [7:0] rb [16];
  int         cur_bl = 0;

  always #4 clk = ~clk;

  spi_eeprom #(.ADDR_BITS(11), .BUF_BYTES(BUF), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n), .so(so));

  function automatic bit bprot(input int b, input int a);
    case (b)
      0: return 1'b0;
      1: return a >= 12'h600;
      2: return a >= 12'h400;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk); sck = 1'b0; si = b[i];
      @(negedge clk); @(negedge clk); r[i] = so;
      sck = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    xbits(b, 8, r);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0; @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); sck = 1'b0; @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel(); xfer(8'h01, r); xfer(v, r); desel();
  endtask

  task automatic wait_idle(output logic [7:0] s);
    s = 8'h01;
    for (int k = 0; k < 40 && s[0]; k++) rdsr(s);
  endtask

  task automatic rd(input int a, input int n);
    logic [7:0] r;
    sel(); xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(8'h00, rb[k]);
    desel();
  endtask

  task automatic wr_raw(input int a, input int n, input int extra);
    logic [7:0] r;
    sel(); xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(wb[k], r);
    if (extra > 0) xbits(8'hA5, extra, r);
    desel();
  endtask

  task automatic model_write(input int a, input int n);
    for (int k = 0; k < n && k < BUF; k++) begin
      int aa = (a + k) % DEP;
      if (!bprot(cur_bl, aa)) begin bmem[aa] = wb[k]; known[aa] = 1'b1; end
    end
  endtask

  task automatic full_write(input int a, input int n);
    logic [7:0] s;
    cmd(8'h06); wr_raw(a, n, 0); model_write(a, n); wait_idle(s);
  endtask

  task automatic compare(input int a, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      int aa = (a + k) % DEP;
      if (known[aa]) chk(rb[k] == bmem[aa], req, rb[k], bmem[aa]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R8: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, s2, r;
    int unsigned seed;
    for (int i = 0; i < DEP; i++) known[i] = 1'b0;
    seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    chk(so == 1'b0, "R1 idle so", so, 0);
    rdsr(s); chk(s == 8'h00, "R4 reset status", s, 8'h00);

    cmd(8'h06); rdsr(s); chk(s == 8'h02, "R3 set latch", s, 8'h02);
    cmd(8'hFF); rdsr(s); chk(s == 8'h02, "R2 unknown code ignored", s, 8'h02);
    cmd(8'h04); rdsr(s); chk(s == 8'h00, "R3 clear latch", s, 8'h00);

    for (int k = 0; k < 4; k++) wb[k] = 8'h10 + 8'(k);
    cmd(8'h06); wr_raw(12'h100, 4, 0); model_write(12'h100, 4);
    rdsr(s); chk(s == 8'h03, "R8 busy after commit", s, 8'h03);
    cmd(8'h04); rdsr(s); chk(s == 8'h03, "R8 clear ignored during busy", s, 8'h03);
    rd(12'h100, 1); chk(rb[0] == 8'h00, "R8 read ignored during busy", rb[0], 0);
    wait_idle(s); chk(s == 8'h00, "R9 latch cleared after busy", s, 8'h00);
    rd(12'h100, 4); compare(12'h100, 4, "R5 sequential read");

    wb[0] = 8'h55; wr_raw(12'h100, 1, 0);
    rdsr(s); chk(s == 8'h00, "R6 write without latch no busy", s, 8'h00);
    rd(12'h100, 1); compare(12'h100, 1, "R6 write without latch");

    for (int k = 0; k < 4; k++) wb[k] = 8'hC0 + 8'(k);
    full_write(12'h7FE, 4);
    rd(12'h7FE, 4); compare(12'h7FE, 4, "R7 write wrap / R5 read wrap");
    rd(16'hF7FF, 2); compare(12'h7FF, 2, "R5 upper address bits ignored");

    cmd(8'h06); wb[0] = 8'h99; wr_raw(12'h101, 1, 3);
    rdsr(s); chk(s == 8'h02, "R6 partial byte dropped", s, 8'h02);
    rd(12'h101, 1); compare(12'h101, 1, "R6 partial byte data");
    cmd(8'h04);

    for (int k = 0; k < 10; k++) wb[k] = 8'h77;
    full_write(12'h208, 2);
    for (int k = 0; k < 10; k++) wb[k] = 8'h30 + 8'(k);
    full_write(12'h200, 10);
    rd(12'h200, 10); compare(12'h200, 10, "R7 buffer limit");
    chk(rb[8] == 8'h77, "R7 extra byte dropped", rb[8], 8'h77);

    cmd(8'h06); rdsr(s); sel(); xfer(8'h05, r);
    xfer(8'h00, s); xfer(8'h00, s2); xfer(8'h00, r); desel();
    chk(s == 8'h02 && s2 == 8'h02 && r == 8'h02, "R4 repeated status", r, 8'h02);
    wrsr(8'hFF); wait_idle(s);
    chk(s == 8'hBC, "R11 status write mask", s, 8'hBC);
    cur_bl = 3;

    for (int k = 0; k < 2; k++) wb[k] = 8'hEE;
    full_write(12'h100, 2);
    rd(12'h100, 2); compare(12'h100, 2, "R10 all protected");

    wp_n = 1'b0; cmd(8'h06); wrsr(8'h00); rdsr(s);
    chk(s == 8'hBE, "R12 pin blocks status write", s, 8'hBE);
    wp_n = 1'b1; wrsr(8'h88); wait_idle(s);
    chk(s == 8'h88, "R12 pin high allows status write", s, 8'h88);
    cur_bl = 2;

    wp_n = 1'b0;
    for (int k = 0; k < 4; k++) wb[k] = 8'h60 + 8'(k);
    full_write(12'h3FE, 4);
    rd(12'h3FE, 4); compare(12'h3FE, 4, "R10 upper half");
    chk(rb[1] == 8'h61, "R12 pin leaves open array writable", rb[1], 8'h61);
    wp_n = 1'b1;

    cmd(8'h06); wrsr(8'h04); wait_idle(s);
    chk(s == 8'h04, "R11 block quarter", s, 8'h04);
    cur_bl = 1;
    for (int k = 0; k < 2; k++) wb[k] = 8'h5A + 8'(k);
    full_write(12'h5FF, 2);
    rd(12'h5FF, 2); compare(12'h5FF, 2, "R10 upper quarter");

    cmd(8'h06); wrsr(8'h00); wait_idle(s); cur_bl = 0;
    chk(s == 8'h00, "R11 clear protect", s, 8'h00);

    for (int it = 0; it < 24; it++) begin
      int a = int'($urandom % DEP);
      int n = 1 + int'($urandom % BUF);
      for (int k = 0; k < n; k++) wb[k] = 8'($urandom);
      full_write(a, n);
      rd(a, n); compare(a, n, "R5/R7 random burst");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule